// File: doc/BRIEF.md
# Cache-Line DMA Burst Splitter

This block sits between a DMA engine and a cache-coherent memory port that only understands small, naturally aligned incrementing bursts. A DMA request carries a start byte address, a byte count and a direction bit. The splitter turns that request into a run of address-channel transfers. Each transfer covers either one full 64-byte cache line or one 16-byte unit, is aligned to its own size and uses the incrementing burst type. Only the address channel is generated here; write data and read data travel on their own channels around the block.

The splitter picks a full line whenever the current address sits on a line boundary and at least a line's worth of bytes remains. Otherwise it steps forward in 16-byte units until it reaches the next boundary or runs out of bytes. Several transfers may be in flight at once. The block counts write or read responses, and after the response for the final transfer it raises a one-cycle done pulse with a status. If any response was not OKAY, that status is a slave error. A request whose start address or length cannot be covered by aligned 16-byte units is refused outright: no transfer goes out and the done pulse reports a slave error.

Top module: `dma_line_splitter`

## Requirements
- R1: `reqReady` is high only while the block is idle. It is never high in a cycle where `addrValid` or `doneValid` is high, and it drops in the cycle after a request is accepted.
- R2: Every emitted transfer has `addrBurst` = 2'b01 (incrementing), `addrSize` = 3'd4 (16-byte beats), and `addrWrite` equal to the `reqWrite` of the accepted request.
- R3: Every emitted transfer is 16 bytes (`addrLen` = 0) with `addrAddr[3:0]` = 0, or 64 bytes (`addrLen` = 3) with `addrAddr[5:0]` = 0.
- R4: A 64-byte transfer is used exactly when the current address is 64-byte aligned and at least 64 bytes remain. Otherwise a 16-byte transfer is used.
- R5: Transfers are issued in ascending address order, one handshake each. The first starts at `reqAddr`, each following one starts where the previous ended, and together they cover exactly `reqLen` bytes.
- R6: A request with `reqAddr[3:0]` != 0, `reqLen[3:0]` != 0, or `reqLen` = 0 issues no transfer. Its done pulse appears in the cycle right after acceptance, with `doneStatus` = 2'b10.
- R7: After all responses have arrived, exactly one `doneValid` pulse of one cycle follows, never before the last response. When all responses were OKAY (2'b00), `doneStatus` = 2'b00.
- R8: If any response carries a code other than 2'b00, `doneStatus` is 2'b10 (slave error), and the block still issues every remaining transfer.
- R9: While `addrValid` is high and `addrReady` is low, the next cycle keeps `addrValid` high and `addrAddr` and `addrLen` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | DMA request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqAddr | input | 32 | Start byte address |
| reqLen | input | 16 | Byte count |
| reqWrite | input | 1 | 1 = write, 0 = read |
| addrValid | output | 1 | Address transfer valid |
| addrReady | input | 1 | Port accepts the address transfer |
| addrAddr | output | 32 | Transfer start address |
| addrLen | output | 8 | Beats minus one |
| addrSize | output | 3 | Beat size code (log2 bytes) |
| addrBurst | output | 2 | Burst type, always incrementing |
| addrWrite | output | 1 | Direction of the transfer |
| respValid | input | 1 | A transfer response arrives |
| respCode | input | 2 | Response code, 2'b00 = OKAY |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | Final status, valid with doneValid |

## Verification
The hardest case to reach is an error response that arrives while the splitter is still issuing addresses and the port is holding off address handshakes. To get there, the error, the backpressure and the in-flight count must all overlap. The bench's responder answers each recorded handshake after a short delay. It can stall `addrReady` in a fixed pattern, slow down its responses, and give a slave error to a chosen response index. Running a misaligned, multi-line request under all three at once brings that overlap about, and the error then has to survive to the final status.

// File: rtl/dma_split_pkg.sv
`timescale 1ns/1ps
package dma_split_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } splitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new request
    logic advance;   // one address handshake completed
    logic respTake;  // one response consumed
  } splitCtl_t;

  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/dma_split_datapath.sv
`timescale 1ns/1ps
module dma_split_datapath
  import dma_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DATA_BYTES = 16,
  parameter int UNIT_BYTES = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  splitCtl_t         ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic [1:0]        respCode,
  output logic              reqLegal,
  output logic [ADDR_W-1:0] curAddr,
  output logic [7:0]        curBeatsM1,
  output logic              curWrite,
  output logic              lastChunk,
  output logic              drained,
  output logic              errFlag
);

  localparam int UNIT_SHIFT = $clog2(UNIT_BYTES);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam int UNIT_BEATS = UNIT_BYTES / DATA_BYTES;
  localparam int LINE_BEATS = LINE_BYTES / DATA_BYTES;
  localparam int CNT_W      = LEN_W - UNIT_SHIFT + 1;

  logic [LEN_W-1:0] remain;
  logic [CNT_W-1:0] outstanding;
  logic             lineOk;
  logic [LEN_W-1:0] chunkBytes;

  // legality of the incoming request: whole 16-byte units, nonzero
  assign reqLegal = (reqAddr[UNIT_SHIFT-1:0] == '0) &&
                    (reqLen[UNIT_SHIFT-1:0] == '0) &&
                    (reqLen != '0);

  // greedy choice: full line when on a line boundary and enough left
  assign lineOk     = (curAddr[LINE_SHIFT-1:0] == '0) &&
                      (remain >= LEN_W'(LINE_BYTES));
  assign chunkBytes = lineOk ? LEN_W'(LINE_BYTES) : LEN_W'(UNIT_BYTES);
  assign curBeatsM1 = lineOk ? 8'(LINE_BEATS - 1) : 8'(UNIT_BEATS - 1);
  assign lastChunk  = (remain == chunkBytes);
  assign drained    = (outstanding == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr     <= '0;
      remain      <= '0;
      curWrite    <= 1'b0;
      errFlag     <= 1'b0;
      outstanding <= '0;
    end else if (ctl.load) begin
      curAddr     <= reqAddr;
      remain      <= reqLen;
      curWrite    <= reqWrite;
      errFlag     <= !reqLegal;
      outstanding <= '0;
    end else begin
      if (ctl.advance) begin
        curAddr <= curAddr + ADDR_W'(chunkBytes);
        remain  <= remain - chunkBytes;
      end
      outstanding <= outstanding + CNT_W'(ctl.advance) - CNT_W'(ctl.respTake);
      if (ctl.respTake && (respCode != RESP_OKAY)) begin
        errFlag <= 1'b1;
      end
    end
  end

  // R5: addresses only move upward within a request
  assert_ascend_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.load && !lastChunk) |=> (curAddr > $past(curAddr)));

endmodule

// File: rtl/dma_split_control.sv
`timescale 1ns/1ps
module dma_split_control
  import dma_split_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqLegal,
  input  logic      addrReady,
  input  logic      respValid,
  input  logic      lastChunk,
  input  logic      drained,
  output splitCtl_t ctl,
  output logic      reqReady,
  output logic      addrValid,
  output logic      doneValid
);

  splitState_t state;
  splitState_t stateNext;

  assign reqReady  = (state == ST_IDLE);
  assign addrValid = (state == ST_ISSUE);
  assign doneValid = (state == ST_DONE);

  always_comb begin
    stateNext    = state;
    ctl.load     = 1'b0;
    ctl.advance  = 1'b0;
    ctl.respTake = respValid;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.load  = 1'b1;
          stateNext = reqLegal ? ST_ISSUE : ST_DONE;
        end
      end
      ST_ISSUE: begin
        if (addrReady) begin
          ctl.advance = 1'b1;
          if (lastChunk) stateNext = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (drained) stateNext = ST_DONE;
      end
      ST_DONE: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R6: an illegal request is answered in the very next cycle
  assert_reject_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqLegal) |=> (doneValid && !addrValid));

  // R7: completion only once every response is back
  assert_done_drained_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> drained);

endmodule

// File: rtl/dma_line_splitter.sv
`timescale 1ns/1ps
module dma_line_splitter
  import dma_split_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DATA_BYTES = 16,
  parameter int UNIT_BYTES = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  output logic              addrValid,
  input  logic              addrReady,
  output logic [ADDR_W-1:0] addrAddr,
  output logic [7:0]        addrLen,
  output logic [2:0]        addrSize,
  output logic [1:0]        addrBurst,
  output logic              addrWrite,
  input  logic              respValid,
  input  logic [1:0]        respCode,
  output logic              doneValid,
  output logic [1:0]        doneStatus
);

  localparam int SIZE_CODE  = $clog2(DATA_BYTES);
  localparam int UNIT_SHIFT = $clog2(UNIT_BYTES);
  localparam int LINE_SHIFT = $clog2(LINE_BYTES);
  localparam int UNIT_LEN   = UNIT_BYTES / DATA_BYTES - 1;
  localparam int LINE_LEN   = LINE_BYTES / DATA_BYTES - 1;

  splitCtl_t ctl;
  logic      reqLegal;
  logic      lastChunk;
  logic      drained;
  logic      errFlag;

  dma_split_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqLegal  (reqLegal),
    .addrReady (addrReady),
    .respValid (respValid),
    .lastChunk (lastChunk),
    .drained   (drained),
    .ctl       (ctl),
    .reqReady  (reqReady),
    .addrValid (addrValid),
    .doneValid (doneValid)
  );

  dma_split_datapath #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .DATA_BYTES (DATA_BYTES),
    .UNIT_BYTES (UNIT_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqWrite   (reqWrite),
    .respCode   (respCode),
    .reqLegal   (reqLegal),
    .curAddr    (addrAddr),
    .curBeatsM1 (addrLen),
    .curWrite   (addrWrite),
    .lastChunk  (lastChunk),
    .drained    (drained),
    .errFlag    (errFlag)
  );

  assign addrSize   = 3'(SIZE_CODE);
  assign addrBurst  = BURST_INCR;
  assign doneStatus = errFlag ? RESP_SLVERR : RESP_OKAY;

  // R3: only unit or line shapes, each aligned to its own size
  assert_legal_shape_R3: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (((addrLen == 8'(UNIT_LEN)) && (addrAddr[UNIT_SHIFT-1:0] == '0)) ||
                   ((addrLen == 8'(LINE_LEN)) && (addrAddr[LINE_SHIFT-1:0] == '0))));

  // R9: a stalled transfer holds still
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrReady) |=> (addrValid && $stable(addrAddr) && $stable(addrLen)));

  // R1: requests taken only when nothing else is going on
  assert_idle_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!addrValid && !doneValid));

endmodule

// File: tb/test_dma_line_splitter.sv
`timescale 1ns/1ps
module test_dma_line_splitter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [15:0] reqLen = '0;
  logic        reqWrite = 1'b0;
  logic        addrValid;
  logic        addrReady = 1'b0;
  logic [31:0] addrAddr;
  logic [7:0]  addrLen;
  logic [2:0]  addrSize;
  logic [1:0]  addrBurst;
  logic        addrWrite;
  logic        respValid = 1'b0;
  logic [1:0]  respCode = 2'b00;
  logic        doneValid;
  logic [1:0]  doneStatus;

  always #2.5 clk = ~clk;

  dma_line_splitter i_dma_line_splitter (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqWrite(reqWrite),
    .addrValid(addrValid), .addrReady(addrReady), .addrAddr(addrAddr),
    .addrLen(addrLen), .addrSize(addrSize), .addrBurst(addrBurst),
    .addrWrite(addrWrite),
    .respValid(respValid), .respCode(respCode),
    .doneValid(doneValid), .doneStatus(doneStatus)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int cyc = 0;

  // responder / monitor controls
  bit stallMode = 1'b0;
  bit slowResp = 1'b0;
  int errAt = -1;

  // records
  logic [31:0] hsAddr [64];
  logic [7:0]  hsLen [64];
  logic [2:0]  hsSize [64];
  logic [1:0]  hsBurst [64];
  logic        hsWrite [64];
  int hsCount = 0;
  int pend = 0;
  int respIdx = 0;
  int doneCnt = 0;
  int doneCyc = 0;
  int respAtDone = 0;
  logic [1:0] doneStat = 2'b00;
  int holdErr = 0;
  int readyBusyErr = 0;
  bit prevStall = 1'b0;
  logic [31:0] prevAddr = '0;
  logic [7:0]  prevLen = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearRecords();
    hsCount = 0; pend = 0; respIdx = 0; doneCnt = 0; holdErr = 0;
    readyBusyErr = 0; prevStall = 1'b0;
  endtask

  // negedge: decide ready, answer earlier handshakes, record new ones
  always @(negedge clk) begin
    if (rstN) begin
      addrReady = !stallMode || (cyc % 3 == 2);
      if (prevStall && (!addrValid || addrAddr != prevAddr || addrLen != prevLen))
        holdErr++;
      prevStall = addrValid && !addrReady;
      prevAddr  = addrAddr;
      prevLen   = addrLen;
      if (reqReady && (addrValid || doneValid)) readyBusyErr++;
      respValid = 1'b0;
      respCode  = 2'b00;
      if (pend > 0 && (!slowResp || cyc[0])) begin
        respValid = 1'b1;
        respCode  = (respIdx == errAt) ? 2'b10 : 2'b00;
        respIdx++;
        pend--;
      end
      if (addrValid && addrReady && hsCount < 64) begin
        hsAddr[hsCount]  = addrAddr;
        hsLen[hsCount]   = addrLen;
        hsSize[hsCount]  = addrSize;
        hsBurst[hsCount] = addrBurst;
        hsWrite[hsCount] = addrWrite;
        hsCount++;
        pend++;
      end
      if (doneValid) begin
        doneCnt++;
        doneStat   = doneStatus;
        doneCyc    = cyc;
        respAtDone = respIdx;
      end
    end
  end

  task automatic runReq(input logic [31:0] a, input logic [15:0] len,
                        input bit wr, input bit stall, input bit slow, input int errIdx);
    int acceptCyc;
    bit r;
    bit legal;
    int expN;
    logic [31:0] ea;
    int rem;
    int wait_n;
    @(posedge clk); #1;
    clearRecords();
    stallMode = stall; slowResp = slow; errAt = errIdx;
    reqAddr = a; reqLen = len; reqWrite = wr; reqValid = 1'b1;
    acceptCyc = 0;
    for (int k = 0; k < 100; k++) begin
      r = reqReady;
      @(posedge clk); #1;
      if (r) begin acceptCyc = cyc; break; end
    end
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R1", "ready after accept", reqReady, 0);
    wait_n = 0;
    while (doneCnt == 0 && wait_n < 3000) begin
      @(posedge clk); #1;
      wait_n++;
    end
    repeat (4) @(posedge clk);
    #1;
    legal = (a[3:0] == 0) && (len[3:0] == 0) && (len != 0);
    chk(doneCnt == 1, "R7", "done pulses", doneCnt, 1);
    chk(readyBusyErr == 0, "R1", "ready while busy", readyBusyErr, 0);
    if (!legal) begin
      chk(hsCount == 0, "R6", "transfers on reject", hsCount, 0);
      chk(doneStat == 2'b10, "R6", "reject status", doneStat, 2'b10);
      chk(doneCyc == acceptCyc, "R6", "reject timing", doneCyc, acceptCyc);
    end else begin
      expN = 0; ea = a; rem = len;
      while (rem > 0) begin
        bit big;
        big = (ea[5:0] == 0) && (rem >= 64);
        if (expN < hsCount) begin
          chk(hsAddr[expN] == ea, "R5", "transfer address", hsAddr[expN], ea);
          chk(hsLen[expN] == (big ? 8'd3 : 8'd0), "R4", "transfer beats",
              hsLen[expN], big ? 3 : 0);
          chk((hsLen[expN] == 8'd3) ? (hsAddr[expN][5:0] == 0) : (hsAddr[expN][3:0] == 0),
              "R3", "alignment", hsAddr[expN], ea);
          chk(hsSize[expN] == 3'd4 && hsBurst[expN] == 2'b01 && hsWrite[expN] == wr,
              "R2", "size/burst/dir", {hsSize[expN], hsBurst[expN], hsWrite[expN]},
              {3'd4, 2'b01, wr});
        end
        ea = ea + (big ? 64 : 16);
        rem = rem - (big ? 64 : 16);
        expN++;
      end
      chk(hsCount == expN, "R5", "transfer count", hsCount, expN);
      chk(respAtDone == expN, "R7", "responses before done", respAtDone, expN);
      if (errIdx >= 0 && errIdx < expN)
        chk(doneStat == 2'b10, "R8", "error status", doneStat, 2'b10);
      else
        chk(doneStat == 2'b00, "R7", "okay status", doneStat, 2'b00);
      chk(holdErr == 0, "R9", "stall hold", holdErr, 0);
    end
  endtask

  task automatic testReset();
    #1;
    chk(reqReady == 1'b1, "R1", "reset ready", reqReady, 1);
    chk(addrValid == 1'b0, "R1", "reset addrValid", addrValid, 0);
    chk(doneValid == 1'b0, "R7", "reset done", doneValid, 0);
  endtask

  task automatic testAlignedLines();  runReq(32'h1000, 16'd256, 1'b1, 0, 0, -1); endtask
  task automatic testMisalignedHead(); runReq(32'h1010, 16'd128, 1'b0, 0, 0, -1); endtask
  task automatic testShortTail();     runReq(32'h2000, 16'd80, 1'b1, 0, 1, -1); endtask
  task automatic testSingleUnit();    runReq(32'h3030, 16'd16, 1'b0, 0, 0, -1); endtask
  task automatic testBackpressure();  runReq(32'h4020, 16'd224, 1'b0, 1, 1, -1); endtask
  task automatic testErrorMid();      runReq(32'h5010, 16'd208, 1'b1, 1, 1, 2); endtask
  task automatic testErrorLast();     runReq(32'h6000, 16'd64, 1'b0, 0, 0, 0); endtask
  task automatic testRejectAddr();    runReq(32'h7008, 16'd64, 1'b1, 0, 0, -1); endtask
  task automatic testRejectLen();     runReq(32'h7000, 16'd40, 1'b0, 0, 0, -1); endtask
  task automatic testRejectZero();    runReq(32'h7000, 16'd0, 1'b1, 0, 0, -1); endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testAlignedLines();
    testMisalignedHead();
    testShortTail();
    testSingleUnit();
    testBackpressure();
    testErrorMid();
    testErrorLast();
    testRejectAddr();
    testRejectLen();
    testRejectZero();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule